// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an 8-bit asynchronous serial port. Software writes bytes into a one-byte holding register. Whenever the shift engine is idle, or is just finishing a frame, the waiting byte moves into the shift engine. The engine sends a low start bit, the data bits with the least significant bit first, an optional parity bit and a high stop bit. Each bit lasts eight pulses of an external baud enable, which runs at eight times the line rate.

Because the holding register is emptied as soon as the engine takes its byte, software can queue the next byte straight away. Consecutive frames then leave the line with no idle time between them. A control/status register sets parity enable and parity sense, enables the interrupt and selects its source. The interrupt source is either the holding register emptying or a whole frame finishing with nothing queued. Both status flags clear when software reads that register.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset the serial line is high, the interrupt is low, and a read of the control/status register (address 1) returns 0x00.
- R2: A frame is one low start bit, then the data bits LSB first, then one high stop bit. Every bit lasts eight baud-enable pulses. The line is high whenever no frame is being sent.
- R3: Control bit 0 enables a parity bit, sent between the last data bit and the stop bit. Control bit 1 selects odd parity (1) or even parity (0), counted over the data bits plus the parity bit.
- R4: A byte written to the data register (address 0) while a frame is in flight waits in the holding register. Its start bit follows the stop bit of the current frame directly, with no idle bit time between them.
- R5: A write to the data register while the holding register is already full is ignored. That byte is never sent.
- R6: Status bit 5 (buffer empty) is set in the cycle the engine takes a byte from the holding register. It stays 0 after reset until the first byte has been written.
- R7: Status bit 6 (complete) is set at the end of a stop bit when no byte is waiting. It is not set between back-to-back frames.
- R8: A read of address 1 returns control bits [3:0] and status bits 5 and 6 on reg_rdata in the cycle after the read strobe, and clears both status bits. A flag that is set in the same cycle as the read stays set. A read of address 0 returns zero.
- R9: Control bit 3 enables the interrupt. Control bit 2 selects its source: 0 for buffer empty, 1 for complete. The irq output follows the selected flag one clock later.
- R10: While a frame is in flight, the line changes only on a clock edge that consumes a baud-enable pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable pulse at eight times the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = data register, 1 = control/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches four things on every cycle. The line must be high while the engine is idle, and every frame must open with a low start bit. While a frame is in flight, the line may change only on baud-enable edges. Each status flag must rise only when the engine is in the matching state: busy for buffer empty, idle for complete. The bench scenarios are the only way to show the remaining behaviour: bit order and parity values, the missing gap between queued frames, a dropped write to a full buffer, clear-on-read, and the interrupt arming only after the first write.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CSR  = 1'b1;

  // control bit positions
  localparam int CB_PAR_EN  = 0;
  localparam int CB_PAR_ODD = 1;
  localparam int CB_IRQ_SEL = 2;
  localparam int CB_IRQ_EN  = 3;
  localparam int CTRL_W     = 4;

  // status bit positions
  localparam int SB_BEMPTY = 5;
  localparam int SB_DONE   = 6;

  typedef enum logic {ENG_IDLE, ENG_SEND} eng_state_e;
endpackage

// File: rtl/ser_tx_regs.sv
module ser_tx_regs
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              buf_take,
  input  logic              frame_done,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_data,
  output logic              par_en,
  output logic              par_odd,
  output logic              bemp_flag,
  output logic              done_flag,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] status_word;
  logic              rd_csr;
  logic              wr_data;
  logic              wr_csr;

  assign rd_csr  = reg_rd && (reg_addr == ADDR_CSR);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_csr  = reg_wr && (reg_addr == ADDR_CSR);
  assign par_en  = ctrl[CB_PAR_EN];
  assign par_odd = ctrl[CB_PAR_ODD];

  always_comb begin
    status_word = '0;
    status_word[CTRL_W-1:0] = ctrl;
    status_word[SB_BEMPTY]  = bemp_flag;
    status_word[SB_DONE]    = done_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      buf_full  <= 1'b0;
      buf_data  <= '0;
      bemp_flag <= 1'b0;
      done_flag <= 1'b0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (wr_data && !buf_full) begin
        buf_data <= reg_wdata;
        buf_full <= 1'b1;
      end else if (buf_take) begin
        buf_full <= 1'b0;
      end
      if (wr_csr) ctrl <= reg_wdata[CTRL_W-1:0];
      if (reg_rd) reg_rdata <= rd_csr ? status_word : '0;
      if (buf_take)    bemp_flag <= 1'b1;
      else if (rd_csr) bemp_flag <= 1'b0;
      if (frame_done)  done_flag <= 1'b1;
      else if (rd_csr) done_flag <= 1'b0;
      irq <= ctrl[CB_IRQ_EN] && (ctrl[CB_IRQ_SEL] ? done_flag : bemp_flag);
    end
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              buf_take,
  output logic              frame_done,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OVERSAMPLE);
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  eng_state_e          state;
  logic [FRAME_W-1:0]  frame;
  logic [FRAME_W-1:0]  new_frame;
  logic [BITS_W-1:0]   bits_left;
  logic [BITS_W-1:0]   new_len;
  logic [CNT_W-1:0]    tick_cnt;
  logic                last_tick;
  logic                end_frame;
  logic                par_bit;

  assign busy       = (state == ENG_SEND);
  assign last_tick  = busy && tick && (tick_cnt == CNT_W'(OVERSAMPLE - 1));
  assign end_frame  = last_tick && (bits_left == BITS_W'(1));
  assign buf_take   = buf_full && (!busy || end_frame);
  assign frame_done = end_frame && !buf_full;

  assign par_bit   = (^buf_data) ^ par_odd;
  assign new_frame = par_en ? {1'b1, par_bit, buf_data, 1'b0}
                            : {1'b1, 1'b1, buf_data, 1'b0};
  assign new_len   = par_en ? BITS_W'(FRAME_W) : BITS_W'(FRAME_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      frame     <= '1;
      bits_left <= '0;
      tick_cnt  <= '0;
      txd       <= 1'b1;
    end else if (buf_take) begin
      state     <= ENG_SEND;
      frame     <= new_frame;
      bits_left <= new_len;
      tick_cnt  <= '0;
      txd       <= 1'b0;
    end else if (end_frame) begin
      state     <= ENG_IDLE;
      tick_cnt  <= '0;
      txd       <= 1'b1;
    end else if (busy && tick) begin
      if (last_tick) begin
        tick_cnt  <= '0;
        frame     <= {1'b1, frame[FRAME_W-1:1]};
        txd       <= frame[1];
        bits_left <= bits_left - BITS_W'(1);
      end else begin
        tick_cnt <= tick_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              txd,
  output logic              irq
);
  logic              buf_take;
  logic              frame_done;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              par_en;
  logic              par_odd;
  logic              bemp_flag;
  logic              done_flag;
  logic              eng_busy;

  ser_tx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .buf_take   (buf_take),
    .frame_done (frame_done),
    .buf_full   (buf_full),
    .buf_data   (buf_data),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .bemp_flag  (bemp_flag),
    .done_flag  (done_flag),
    .irq        (irq)
  );

  ser_tx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (baud_tick),
    .buf_full   (buf_full),
    .buf_data   (buf_data),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .buf_take   (buf_take),
    .frame_done (frame_done),
    .busy       (eng_busy),
    .txd        (txd)
  );
endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic txd,
  input logic eng_busy,
  input logic buf_full,
  input logic bemp_flag,
  input logic done_flag
);
  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> txd);

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> !txd);

  // R10
  txd_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && $past(eng_busy) && !$past(baud_tick)) |-> $stable(txd));

  // R7
  done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> !eng_busy);

  // R6
  bempty_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bemp_flag) |-> (eng_busy && $past(buf_full)));
endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .baud_tick (baud_tick),
  .txd       (txd),
  .eng_busy  (eng_busy),
  .buf_full  (buf_full),
  .bemp_flag (bemp_flag),
  .done_flag (done_flag)
);

// File: tb/ser_tx_dbuf_tb.sv
module ser_tx_dbuf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BITCLK     = TDIV * 8;
  localparam int HALFBIT    = BITCLK / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       txd;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int frames_done = 0;

  ser_tx_dbuf u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .txd(txd), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin : tick_gen
    int tdiv = 0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv + 1) % TDIV;
      baud_tick = (tdiv == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_csr(output logic [7:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic recv(input bit has_par, output logic [7:0] d, output logic p,
                      output int t_start, output int t_stop);
    int guard = 0;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    t_start = cyc;
    repeat (HALFBIT) @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITCLK) @(negedge clk);
      d[i] = txd;
    end
    p = 1'b0;
    if (has_par) begin
      repeat (BITCLK) @(negedge clk);
      p = txd;
    end
    repeat (BITCLK) @(negedge clk);
    chk(txd == 1'b1, "R2 stop bit", txd, 1);
    t_stop = cyc;
    frames_done++;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk(txd == 1'b1, "R1 line idle high", txd, 1);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    rd_csr(v);
    chk(v == 8'h00, "R1 csr after reset", v, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d, v; logic p; int ts, te;
    wr(1'b0, 8'hA5);
    recv(1'b0, d, p, ts, te);
    chk(d == 8'hA5, "R2 data LSB first", d, 8'hA5);
    repeat (40) @(negedge clk);
    chk(txd == 1'b1, "R2 idle after frame", txd, 1);
    rd_csr(v);
    chk(v == 8'h60, "R6 R7 flags after one frame", v, 8'h60);
    rd_csr(v);
    chk(v == 8'h00, "R8 clear on read", v, 8'h00);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b0;
    @(negedge clk); reg_rd = 1'b0;
    chk(reg_rdata == 8'h00, "R8 data address reads zero", reg_rdata, 0);
  endtask

  task automatic t_parity();
    logic [7:0] d; logic p; int ts, te;
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h07);
    recv(1'b1, d, p, ts, te);
    chk(d == 8'h07, "R3 data even", d, 8'h07);
    chk(p == 1'b1, "R3 even parity 0x07", p, 1);
    wr(1'b0, 8'h03);
    recv(1'b1, d, p, ts, te);
    chk(p == 1'b0, "R3 even parity 0x03", p, 0);
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h07);
    recv(1'b1, d, p, ts, te);
    chk(p == 1'b0, "R3 odd parity 0x07", p, 0);
    repeat (60) @(negedge clk);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_backtoback();
    logic [7:0] d1, d2, v; logic p; int s1, e1, s2, e2; int lows = 0;
    int fd0;
    logic [7:0] rv;
    rd_csr(v);
    fd0 = frames_done;
    fork
      begin
        recv(1'b0, d1, p, s1, e1);
        recv(1'b0, d2, p, s2, e2);
      end
      begin
        wr(1'b0, 8'h11);
        repeat (5) @(negedge clk);
        wr(1'b0, 8'h22);
        wr(1'b0, 8'h33);
        rd_csr(rv);
        chk(rv == 8'h20, "R6 bempty after first take", rv, 8'h20);
        wait (frames_done == fd0 + 1);
        repeat (24) @(negedge clk);
        rd_csr(rv);
        chk(rv == 8'h20, "R7 no complete between queued frames", rv, 8'h20);
      end
    join
    chk(d1 == 8'h11, "R4 first byte", d1, 8'h11);
    chk(d2 == 8'h22, "R4 queued byte", d2, 8'h22);
    chk((s2 - e1) >= 12 && (s2 - e1) <= 20, "R4 no idle gap", s2 - e1, 16);
    repeat (40) @(negedge clk);
    rd_csr(v);
    chk(v == 8'h40, "R7 complete after last frame", v, 8'h40);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk(lows == 0, "R5 write to full buffer dropped", lows, 0);
  endtask

  task automatic t_irq();
    logic [7:0] d, v; logic p; int ts, te;
    do_reset();
    wr(1'b1, 8'h08);
    repeat (60) @(negedge clk);
    chk(irq == 1'b0, "R6 R9 not armed before first write", irq, 0);
    wr(1'b0, 8'h5A);
    repeat (6) @(negedge clk);
    chk(irq == 1'b1, "R9 buffer-empty irq", irq, 1);
    rd_csr(v);
    chk(v == 8'h28, "R8 csr with bempty", v, 8'h28);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R8 R9 irq drops after read", irq, 0);
    recv(1'b0, d, p, ts, te);
    chk(d == 8'h5A, "R2 data 0x5A", d, 8'h5A);
    repeat (40) @(negedge clk);
    chk(irq == 1'b0, "R9 complete ignored in buffer mode", irq, 0);
    wr(1'b1, 8'h0C);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9 complete irq", irq, 1);
    rd_csr(v);
    chk(v == 8'h4C, "R8 csr with complete", v, 8'h4C);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R9 complete irq cleared", irq, 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    t_reset();
    t_basic();
    t_parity();
    t_backtoback();
    t_irq();
    finish_run();
  end
endmodule